// File: doc/BRIEF.md
# Gated Frequency and Period Meter

This block measures either the frequency or the period of a tuner-side signal and leaves the result in a 20-bit binary count. In frequency mode it counts rising edges of one of two inputs during a gate window. The window lasts a chosen number of millisecond strobes. The high-band input goes through a divide-by-two stage first, and the low-band input is counted as it arrives. In period mode it counts reference-tick enables over one or two whole periods of the low-band input. Before the gate opens or the span is armed, a settling wait runs. Its length depends on the gate selection and on whether the input bias is held.

A controller presents a control word and pulses a load strobe. A word with the run bit clear stops the meter and clears it. A word whose run bit goes from clear to set starts a fresh measurement. A word that arrives while the run bit is already set starts another measurement whose result is added to the held count, which gives an integrating count. A completion flag reports the end of a measurement. A pull-down request for the analog front end is derived from the latched control word.

Top module: `gate_meter`

## Requirements
- R1: After reset `meas_count` is 0, `meas_done` is 0 and `in_pulldown` is 1.
- R2: `ctl_src` picks the source and mode. Codes `1x` select the high-band input in frequency mode, `01` selects the low-band input in frequency mode, and `00` selects the low-band input in period mode. The input that is not selected has no effect on the count.
- R3: In high-band frequency mode the count equals the number of high-band rising edges inside the gate, divided by two and rounded down. The divider is cleared when the gate opens.
- R4: In frequency mode, `ctl_gate` codes 00, 01, 10 and 11 give a gate of 4, 8, 32 and 64 millisecond strobes. The gate opens at the strobe that ends the wait.
- R5: In period mode, `ctl_gate[1]`=0 spans one low-band period and `ctl_gate[1]`=1 spans two. The count is the number of reference ticks from the cycle after the opening rising edge up to and including the closing rising edge.
- R6: A load with `ctl_run`=0 clears the count and the completion flag in the next cycle.
- R7: A load with `ctl_run`=1 while the latched run bit is 0 starts a measurement from a count of 0.
- R8: A load with `ctl_run`=1 while the latched run bit is already 1 starts a measurement that adds to the held count, modulo 2^20.
- R9: Before the gate or span, the wait lasts 2 strobes when `ctl_hold_bias`=1. When `ctl_hold_bias`=0 it lasts 4 strobes if `ctl_gate[1]`=0 and 8 strobes if `ctl_gate[1]`=1.
- R10: `meas_done` rises when the gate or span ends. It stays high, with the count frozen, until the next load.
- R11: `in_pulldown` is 1 exactly when the latched `ctl_hold_bias` and the latched run bit are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference-tick enable counted in period mode |
| ms_strobe | input | 1 | One-cycle millisecond strobe |
| hb_in | input | 1 | Synchronised high-band input |
| lb_in | input | 1 | Synchronised low-band input |
| ctl_load | input | 1 | Latches the control fields for one cycle |
| ctl_src | input | 2 | Source and mode select |
| ctl_gate | input | 2 | Gate length or period count |
| ctl_run | input | 1 | Run (1) or stop and clear (0) |
| ctl_hold_bias | input | 1 | Keep bias: shorter wait, no pull-down |
| meas_count | output | 20 | Measurement result |
| meas_done | output | 1 | Measurement complete |
| in_pulldown | output | 1 | Pull-down request for the selected input |

## Verification
The bench toggles the unselected input during every measurement. A meter that mixes up the source decode would therefore show an inflated count. It runs all four gate lengths and both wait lengths, and it times each run from load to completion. A wrong window or wait table shows up either as a count that is off by whole milliseconds' worth of edges or as completion about 80 cycles early or late. The tests repeat a load with run already set, expecting the sum, and then stop and restart, expecting a fresh count. These catch a meter that always clears, or one that never clears. A period run with two spans checks that the closing edge is not counted twice and that the opening edge is not counted.

// File: rtl/gm_pkg.sv
// Shared types for the gated meter: sequencer states and the latched control word.
package gm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_WAIT, ST_GATE, ST_ARM, ST_SPAN, ST_DONE
    } gm_state_e;

    typedef struct packed {
        logic [1:0] src;
        logic [1:0] gate;
        logic       run;
        logic       bias;
    } gm_ctl_t;
endpackage

// File: rtl/gm_edge_src.sv
// Rising-edge detection on both inputs and the high-band divide-by-two.
// Assumes both inputs are already synchronised to clk.
module gm_edge_src (
    input  logic clk,
    input  logic rst_n,
    input  logic hb_in,
    input  logic lb_in,
    input  logic use_hb,
    input  logic restart,
    output logic ev_freq,
    output logic lb_rise
);
    logic hb_d, lb_d, half;
    logic hb_rise;

    assign hb_rise = hb_in & ~hb_d;
    assign lb_rise = lb_in & ~lb_d;
    // divider emits on every second high-band edge
    assign ev_freq = use_hb ? (hb_rise & half) : lb_rise;

    // previous-value registers for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_d <= 1'b0;
            lb_d <= 1'b0;
        end else begin
            hb_d <= hb_in;
            lb_d <= lb_in;
        end
    end

    // divide-by-two phase, cleared at gate open
    always_ff @(posedge clk) begin
        if (!rst_n || restart) half <= 1'b0;
        else if (hb_rise)      half <= ~half;
    end

    a_r3_half_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_rise && !restart) |=> (half != $past(half)));
endmodule

// File: rtl/gm_win_timer.sv
// Counts millisecond strobes up to a length; pulses expire on the last one.
// Assumes len >= 1 and stays constant while run is high.
module gm_win_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             strobe,
    input  logic [TMR_W-1:0] len,
    output logic             expire
);
    logic [TMR_W-1:0] cnt;

    assign expire = run && strobe && (cnt == len - 1'b1);

    // strobe counter, restarted on clear or expiry
    always_ff @(posedge clk) begin
        if (!rst_n || clear || expire) cnt <= '0;
        else if (run && strobe)        cnt <= cnt + 1'b1;
    end

    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear) |-> (cnt < len));
endmodule

// File: rtl/gm_seq.sv
// Measurement sequencer: wait, then gate (frequency) or arm and span (period),
// then done. Produces the count increment, divider restart and done flag.
// Assumes ctl already holds the word latched by the previous load.
module gm_seq
    import gm_pkg::*;
#(
    parameter int TMR_W      = 8,
    parameter int GATE_0     = 4,
    parameter int GATE_1     = 8,
    parameter int GATE_2     = 32,
    parameter int GATE_3     = 64,
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int WAIT_FAST  = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  logic    run_new,
    input  gm_ctl_t ctl,
    input  logic    ms_strobe,
    input  logic    ref_tick,
    input  logic    ev_freq,
    input  logic    lb_rise,
    output logic    inc,
    output logic    restart,
    output logic    done
);
    gm_state_e        state;
    logic             pcnt;
    logic             period_md;
    logic             tmr_exp;
    logic             tmr_run;
    logic [TMR_W-1:0] gate_len, wait_len, tmr_len;

    assign period_md = (ctl.src == 2'b00);

    // gate and wait lengths in strobes
    always_comb begin
        case (ctl.gate)
            2'b00:   gate_len = TMR_W'(GATE_0);
            2'b01:   gate_len = TMR_W'(GATE_1);
            2'b10:   gate_len = TMR_W'(GATE_2);
            default: gate_len = TMR_W'(GATE_3);
        endcase
        if (ctl.bias)         wait_len = TMR_W'(WAIT_FAST);
        else if (ctl.gate[1]) wait_len = TMR_W'(WAIT_LONG);
        else                  wait_len = TMR_W'(WAIT_SHORT);
    end

    assign tmr_run = (state == ST_WAIT) || (state == ST_GATE);
    assign tmr_len = (state == ST_GATE) ? gate_len : wait_len;

    gm_win_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (load),
        .run    (tmr_run),
        .strobe (ms_strobe),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    // phase sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pcnt  <= 1'b0;
        end else if (load) begin
            state <= run_new ? ST_WAIT : ST_IDLE;
            pcnt  <= 1'b0;
        end else begin
            case (state)
                ST_WAIT: if (tmr_exp) state <= period_md ? ST_ARM : ST_GATE;
                ST_GATE: if (tmr_exp) state <= ST_DONE;
                ST_ARM:  if (lb_rise) begin
                    state <= ST_SPAN;
                    pcnt  <= 1'b0;
                end
                ST_SPAN: if (lb_rise) begin
                    if (pcnt == ctl.gate[1]) state <= ST_DONE;
                    else                     pcnt  <= 1'b1;
                end
                default: state <= state;
            endcase
        end
    end

    assign restart = (state == ST_WAIT) && tmr_exp;
    assign inc     = ((state == ST_GATE) && ev_freq) || ((state == ST_SPAN) && ref_tick);
    assign done    = (state == ST_DONE);

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
    a_r5_span_needs_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPAN) |-> (ctl.src == 2'b00));
endmodule

// File: rtl/gate_meter.sv
// Top of the gated frequency/period meter: latches the control word on load,
// keeps the result register (clear, fresh start or integrate) and drives the
// pull-down request. Assumes hb_in/lb_in are synchronous to clk.
module gate_meter
    import gm_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int TMR_W      = 8,
    parameter int GATE_0     = 4,
    parameter int GATE_1     = 8,
    parameter int GATE_2     = 32,
    parameter int GATE_3     = 64,
    parameter int WAIT_SHORT = 4,
    parameter int WAIT_LONG  = 8,
    parameter int WAIT_FAST  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             ms_strobe,
    input  logic             hb_in,
    input  logic             lb_in,
    input  logic             ctl_load,
    input  logic [1:0]       ctl_src,
    input  logic [1:0]       ctl_gate,
    input  logic             ctl_run,
    input  logic             ctl_hold_bias,
    output logic [CNT_W-1:0] meas_count,
    output logic             meas_done,
    output logic             in_pulldown
);
    gm_ctl_t ctl_q;
    logic    ev_freq, lb_rise, inc, restart;

    // control word latch
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= '0;
        else if (ctl_load) ctl_q <= '{src: ctl_src, gate: ctl_gate, run: ctl_run, bias: ctl_hold_bias};
    end

    gm_edge_src u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .hb_in   (hb_in),
        .lb_in   (lb_in),
        .use_hb  (ctl_q.src[1]),
        .restart (restart),
        .ev_freq (ev_freq),
        .lb_rise (lb_rise)
    );

    gm_seq #(
        .TMR_W(TMR_W), .GATE_0(GATE_0), .GATE_1(GATE_1), .GATE_2(GATE_2),
        .GATE_3(GATE_3), .WAIT_SHORT(WAIT_SHORT), .WAIT_LONG(WAIT_LONG),
        .WAIT_FAST(WAIT_FAST)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ctl_load),
        .run_new   (ctl_run),
        .ctl       (ctl_q),
        .ms_strobe (ms_strobe),
        .ref_tick  (ref_tick),
        .ev_freq   (ev_freq),
        .lb_rise   (lb_rise),
        .inc       (inc),
        .restart   (restart),
        .done      (meas_done)
    );

    // result register: stop clears, fresh start clears, repeat start integrates
    always_ff @(posedge clk) begin
        if (!rst_n)                                   meas_count <= '0;
        else if (ctl_load && (!ctl_run || !ctl_q.run)) meas_count <= '0;
        else if (!ctl_load && inc)                    meas_count <= meas_count + 1'b1;
    end

    assign in_pulldown = !ctl_q.bias && !ctl_q.run;

    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_load && !ctl_run) |=> (meas_count == '0 && !meas_done));
    a_r7_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_load && ctl_run && !ctl_q.run) |=> (meas_count == '0));
    a_r10_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && !ctl_load) |=> $stable(meas_count));
    a_r11_bias_no_pull: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_load && ctl_hold_bias) |=> !in_pulldown);
endmodule

// File: tb/gate_meter_tb.sv
// Scoreboard bench: the driver pushes expected counts, the monitor pops them
// on each rising completion flag and compares them against the result.
module gate_meter_tb;
    localparam int MS  = 40;
    localparam int PER = 160;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick, ms_strobe, hb_in, lb_in;
    logic        ctl_load, ctl_run, ctl_hold_bias;
    logic [1:0]  ctl_src, ctl_gate;
    logic [19:0] meas_count;
    logic        meas_done, in_pulldown;

    int          n_run = 0, n_fail = 0;
    int          ph = 0, gc = 0, pc = 0;
    int          khi = 0, klo = 0;
    logic        per_mode = 1'b0;
    int          exp_q[$];
    string       tag_q[$];
    logic        done_d = 1'b0;

    always #2 clk = ~clk;

    gate_meter u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .ms_strobe(ms_strobe),
        .hb_in(hb_in), .lb_in(lb_in), .ctl_load(ctl_load), .ctl_src(ctl_src),
        .ctl_gate(ctl_gate), .ctl_run(ctl_run), .ctl_hold_bias(ctl_hold_bias),
        .meas_count(meas_count), .meas_done(meas_done), .in_pulldown(in_pulldown)
    );

    function automatic logic pulse(int p, int k);
        return (p >= 4) && (p < 4 + 4*k) && (((p - 4) % 4) < 2);
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // stimulus generator: strobes, ticks and both signal inputs
    initial begin
        ms_strobe = 0; ref_tick = 0; hb_in = 0; lb_in = 0;
        forever begin
            @(negedge clk);
            ph = (ph == MS-1) ? 0 : ph + 1;
            pc = (pc == PER-1) ? 0 : pc + 1;
            gc++;
            ms_strobe = (ph == 0);
            ref_tick  = ((gc % 4) == 2);
            hb_in     = pulse(ph, khi);
            lb_in     = per_mode ? (pc < PER/2) : pulse(ph, klo);
        end
    end

    // monitor: compare on every rising completion
    initial begin
        forever begin
            @(negedge clk);
            if (meas_done && !done_d) begin
                if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", meas_count, -1);
                else begin
                    automatic int    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(meas_count == 20'(e), t, meas_count, e);
                end
            end
            done_d = meas_done;
        end
    end

    task automatic load(input logic [1:0] s, input logic [1:0] g, input logic r, input logic b);
        @(posedge clk);
        while (ph != 0) @(posedge clk);
        @(negedge clk);
        ctl_src = s; ctl_gate = g; ctl_run = r; ctl_hold_bias = b; ctl_load = 1'b1;
        @(negedge clk);
        ctl_load = 1'b0;
    endtask

    // run one measurement; expc < 0 skips the timing check
    task automatic meas(input logic [1:0] s, input logic [1:0] g, input logic b,
                        input int expv, input string tag, input int expc);
        int t;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        load(s, g, 1'b1, b);
        t = 1;
        while (!meas_done && t < 6000) begin @(negedge clk); t++; end
        if (expc >= 0)
            chk((t >= expc - 4) && (t <= expc + 4), {tag, " timing R9"}, t, expc);
        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, {tag, " completion seen R10"}, exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int snap;
        rst_n = 0; ctl_load = 0; ctl_src = 0; ctl_gate = 0; ctl_run = 0; ctl_hold_bias = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(meas_count == 0, "R1 count", meas_count, 0);
        chk(meas_done == 0, "R1 done", meas_done, 0);
        chk(in_pulldown == 1, "R1 pulldown", in_pulldown, 1);

        // R2/R4/R9: low band, gate 00, high band busy and ignored
        khi = 7; klo = 5;
        meas(2'b01, 2'b00, 1'b0, 20, "R2 R4 low band gate00", (4+4)*MS);
        chk(in_pulldown == 0, "R11 running", in_pulldown, 0);
        // R8: integrate on repeat start
        meas(2'b01, 2'b00, 1'b0, 40, "R8 integrate", (4+4)*MS);
        // R10: done and count hold
        snap = meas_count;
        repeat (50) @(negedge clk);
        chk(meas_done == 1, "R10 done holds", meas_done, 1);
        chk(meas_count == 20'(snap), "R10 count frozen", meas_count, snap);
        // R6: stop clears
        load(2'b01, 2'b00, 1'b0, 1'b0);
        @(negedge clk);
        chk(meas_count == 0, "R6 clear count", meas_count, 0);
        chk(meas_done == 0, "R6 clear done", meas_done, 0);
        chk(in_pulldown == 1, "R11 stopped", in_pulldown, 1);

        // R3/R2: high band divided, low band busy and ignored, fast wait (R9)
        khi = 6; klo = 9;
        meas(2'b10, 2'b01, 1'b1, 24, "R3 high band gate01", (2+8)*MS);
        // stop, then R7 fresh start, gate 10 with long wait
        load(2'b01, 2'b00, 1'b0, 1'b0);
        khi = 9; klo = 3;
        meas(2'b01, 2'b10, 1'b0, 96, "R7 R4 fresh gate10", (8+32)*MS);
        load(2'b01, 2'b00, 1'b0, 1'b0);
        klo = 2;
        meas(2'b01, 2'b11, 1'b1, 128, "R4 gate11", (2+64)*MS);

        // R5: period mode, one and two spans
        load(2'b00, 2'b00, 1'b0, 1'b1);
        @(negedge clk);
        chk(in_pulldown == 0, "R11 bias held", in_pulldown, 0);
        per_mode = 1'b1; khi = 8;
        meas(2'b00, 2'b00, 1'b1, PER/4, "R5 one period", -1);
        load(2'b00, 2'b00, 1'b0, 1'b0);
        meas(2'b00, 2'b10, 1'b0, PER/2, "R5 two periods", -1);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule